// File: doc/BRIEF.md
# Exception Priority Masking Unit

This block picks which pending exception a small processor core may enter next. Request lines and a supervisor-call request set pending bits. Each configurable exception has its own programmable 8-bit priority, where a smaller number is more urgent. Two masking registers gate admission. A one-bit global mask shuts out every configurable exception. A base threshold shuts out every configurable exception whose priority value is at or above it. The core also supplies its current execution priority, and a winner must be strictly more urgent than that level.

A supervisor call that cannot be admitted when it arrives is not kept pending. It is turned into a hard fault at once. The hard fault has a fixed priority above every configurable level, and no mask stops it. When the hard fault is taken and the fault-catch bit of the debug control register is set, a halt request pulses toward the debug port. Software programs the registers through a simple write port and reads them back through a registered read port.

Top module: `epm_unit`

## Requirements
- R1: After reset, `take`, `halt_req` and `take_num` are 0. Every priority, the global mask, the threshold and the catch bit read back as 0.
- R2: Register map on `wr_addr`/`rd_addr`. An address i below NUM_LINES+1 holds the priority of slot i, where slot 0 is the supervisor call and slot k is line k-1. NUM_LINES+1 holds the global mask in bit 0. NUM_LINES+2 holds the threshold. NUM_LINES+3 holds the fault-catch bit in bit 0. Priorities and the threshold keep only their upper PRIO_BITS bits, and the lower bits read as 0. Other addresses read as 0. `rd_data` shows the addressed register one clock after `rd_addr` is applied.
- R3: Exception numbers are 1 for the hard fault, 2 for the supervisor call, and 3+k for line k. Among admitted pending configurable exceptions, the smallest priority value wins. On equal values the lower exception number wins.
- R4: While the global mask is 1, no configurable exception is taken.
- R5: A threshold of 0 blocks nothing. A nonzero threshold blocks every configurable exception whose priority is greater than or equal to it, and exceptions with smaller values still pass.
- R6: While `exec_active` is 1, a configurable exception is taken only if its priority is strictly less than `exec_prio`. While `exec_in_fault` is 1, nothing is taken.
- R7: A supervisor-call request that is refused on arrival makes the hard fault pending and leaves the supervisor call not pending. A request is refused by the global mask, by the threshold, or by the execution priority.
- R8: A pending hard fault beats every configurable exception and ignores the global mask and the threshold. It is held while `exec_in_fault` is 1 and is taken once that input falls.
- R9: `halt_req` pulses together with a hard-fault take exactly when the catch bit is 1.
- R10: A request sampled at clock edge n gives a one-cycle `take` with `take_num` after edge n+1. The taken pending bit clears at the following edge, so it is not taken again. Two takes never occur in adjacent cycles, and a second pending exception follows two cycles after the first.
- R11: Set the supervisor call to priority 0 and the threshold to the next usable level. The supervisor call is then taken without escalation while all lines with nonzero priority stay blocked and pending. Once the threshold is cleared, they are taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_req | input | NUM_LINES | Request pulses, one per line |
| svc_req | input | 1 | Supervisor-call request pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | clog2(NUM_LINES+4) | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | clog2(NUM_LINES+4) | Read address |
| rd_data | output | 8 | Registered read data |
| exec_active | input | 1 | Core is running at an exception priority |
| exec_prio | input | 8 | Current execution priority |
| exec_in_fault | input | 1 | Core is running the hard-fault handler |
| take | output | 1 | One-cycle take strobe |
| take_num | output | clog2(NUM_LINES+3) | Number of the exception taken, 0 when idle |
| halt_req | output | 1 | Debug halt request pulse |

## Verification
The checks assume that requests arrive as single-cycle pulses and are not held high. A held line would set its pending bit again after each take. They also assume that `exec_in_fault` stays high for as long as the fault handler runs, and that the execution inputs do not change inside a decision window. The bench raises each request for exactly one cycle, changes the execution inputs and the registers only between windows, and resets the block before each table vector. This means no state carries over from one vector to the next.

// File: rtl/epm_pkg.sv
package epm_pkg;
  localparam int EXC_NONE  = 0;
  localparam int EXC_FAULT = 1;
  localparam int EXC_SVC   = 2;
  localparam int PRIO_W    = 8;

  typedef logic [PRIO_W-1:0] prio_t;

  // keep the implemented upper bits of a priority value
  function automatic prio_t prio_trim(input prio_t v, input int bits);
    prio_t keep;
    keep = prio_t'(8'hFF << (PRIO_W - bits));
    return v & keep;
  endfunction
endpackage

// File: rtl/epm_regs.sv
module epm_regs
  import epm_pkg::*;
#(
  parameter int NUM_CFG   = 7,
  parameter int PRIO_BITS = 3,
  parameter int AW        = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [7:0]                wr_data,
  input  logic [AW-1:0]             rd_addr,
  output logic [7:0]                rd_data,
  output logic [NUM_CFG*PRIO_W-1:0] prio_flat,
  output logic                      gmask,
  output prio_t                     thr,
  output logic                      catch_en
);
  localparam int ADDR_MASK  = NUM_CFG;
  localparam int ADDR_THR   = NUM_CFG + 1;
  localparam int ADDR_CATCH = NUM_CFG + 2;

  prio_t prio_q [NUM_CFG];
  logic  gmask_q, catch_q;
  prio_t thr_q;
  logic [7:0] rd_q;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        prio_q[i] <= '0;
      else if (wr_en && wr_addr == AW'(i))
        prio_q[i] <= prio_trim(wr_data, PRIO_BITS);
    end
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gmask_q <= 1'b0;
      thr_q   <= '0;
      catch_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADDR_MASK))  gmask_q <= wr_data[0];
      if (wr_addr == AW'(ADDR_THR))   thr_q   <= prio_trim(wr_data, PRIO_BITS);
      if (wr_addr == AW'(ADDR_CATCH)) catch_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      rd_q <= '0;
      for (int i = 0; i < NUM_CFG; i++)
        if (rd_addr == AW'(i)) rd_q <= prio_q[i];
      if (rd_addr == AW'(ADDR_MASK))  rd_q <= {7'd0, gmask_q};
      if (rd_addr == AW'(ADDR_THR))   rd_q <= thr_q;
      if (rd_addr == AW'(ADDR_CATCH)) rd_q <= {7'd0, catch_q};
    end
  end

  assign rd_data  = rd_q;
  assign gmask    = gmask_q;
  assign thr      = thr_q;
  assign catch_en = catch_q;
endmodule

// File: rtl/epm_pending.sv
module epm_pending #(
  parameter int NUM_CFG = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CFG-1:0] set_vec,
  input  logic               svc_refused,
  input  logic [NUM_CFG-1:0] clr_vec,
  input  logic               clr_fault,
  output logic [NUM_CFG-1:0] pend,
  output logic               fault_pend
);
  logic [NUM_CFG-1:0] pend_q;
  logic               fault_q;
  logic [NUM_CFG-1:0] set_ok;

  // a refused supervisor call never becomes pending as itself
  assign set_ok = set_vec & ~{{(NUM_CFG-1){1'b0}}, svc_refused};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      pend_q  <= (pend_q & ~clr_vec) | set_ok;
      fault_q <= (fault_q & ~clr_fault) | (set_vec[0] & svc_refused);
    end
  end

  assign pend       = pend_q;
  assign fault_pend = fault_q;
endmodule

// File: rtl/epm_arbiter.sv
module epm_arbiter
  import epm_pkg::*;
#(
  parameter int NUM_CFG = 7,
  parameter int NW      = 4
) (
  input  logic [NUM_CFG-1:0]        pend,
  input  logic                      fault_pend,
  input  logic [NUM_CFG*PRIO_W-1:0] prio_flat,
  input  logic                      gmask,
  input  prio_t                     thr,
  input  logic                      exec_active,
  input  prio_t                     exec_prio,
  input  logic                      exec_in_fault,
  input  logic                      hold,
  output logic                      svc_refused,
  output logic                      win_valid,
  output logic                      win_fault,
  output logic [NUM_CFG-1:0]        win_sel,
  output logic [NW-1:0]             win_num
);
  prio_t pr [NUM_CFG];
  logic [NUM_CFG-1:0] admit;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_admit
    assign pr[i]    = prio_flat[i*PRIO_W +: PRIO_W];
    assign admit[i] = !gmask
                   && !(thr != '0 && pr[i] >= thr)
                   && (!exec_active || pr[i] < exec_prio)
                   && !exec_in_fault;
  end

  assign svc_refused = !admit[0];

  always_comb begin
    prio_t best;
    best      = '0;
    win_valid = 1'b0;
    win_fault = 1'b0;
    win_sel   = '0;
    win_num   = '0;
    if (!hold) begin
      if (fault_pend && !exec_in_fault) begin
        win_valid = 1'b1;
        win_fault = 1'b1;
        win_num   = NW'(EXC_FAULT);
      end else begin
        for (int i = 0; i < NUM_CFG; i++) begin
          if (pend[i] && admit[i] && (!win_valid || pr[i] < best)) begin
            win_valid = 1'b1;
            best      = pr[i];
            win_sel   = NUM_CFG'(1) << i;
            win_num   = NW'(i + EXC_SVC);
          end
        end
      end
    end
  end
endmodule

// File: rtl/epm_unit.sv
module epm_unit
  import epm_pkg::*;
#(
  parameter int NUM_LINES = 6,
  parameter int PRIO_BITS = 3,
  localparam int NUM_CFG  = NUM_LINES + 1,
  localparam int AW       = $clog2(NUM_CFG + 3),
  localparam int NW       = $clog2(NUM_LINES + 3)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_req,
  input  logic                 svc_req,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [7:0]           rd_data,
  input  logic                 exec_active,
  input  logic [7:0]           exec_prio,
  input  logic                 exec_in_fault,
  output logic                 take,
  output logic [NW-1:0]        take_num,
  output logic                 halt_req
);
  logic [NUM_CFG*PRIO_W-1:0] prio_flat;
  logic                      gmask_w, catch_w;
  prio_t                     thr_w;
  logic [NUM_CFG-1:0]        pend_w;
  logic                      fault_pend_w;
  logic                      svc_refused_w;
  logic                      win_valid, win_fault;
  logic [NUM_CFG-1:0]        win_sel;
  logic [NW-1:0]             win_num;

  logic                      take_q, halt_q, fault_q;
  logic [NW-1:0]             num_q;
  logic [NUM_CFG-1:0]        sel_q;

  epm_regs #(.NUM_CFG(NUM_CFG), .PRIO_BITS(PRIO_BITS), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .prio_flat(prio_flat),
    .gmask(gmask_w), .thr(thr_w), .catch_en(catch_w)
  );

  epm_pending #(.NUM_CFG(NUM_CFG)) u_pend (
    .clk(clk), .rst(rst), .set_vec({line_req, svc_req}),
    .svc_refused(svc_refused_w),
    .clr_vec(take_q ? sel_q : '0), .clr_fault(take_q & fault_q),
    .pend(pend_w), .fault_pend(fault_pend_w)
  );

  epm_arbiter #(.NUM_CFG(NUM_CFG), .NW(NW)) u_arb (
    .pend(pend_w), .fault_pend(fault_pend_w), .prio_flat(prio_flat),
    .gmask(gmask_w), .thr(thr_w), .exec_active(exec_active),
    .exec_prio(exec_prio), .exec_in_fault(exec_in_fault), .hold(take_q),
    .svc_refused(svc_refused_w), .win_valid(win_valid), .win_fault(win_fault),
    .win_sel(win_sel), .win_num(win_num)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q  <= 1'b0;
      halt_q  <= 1'b0;
      fault_q <= 1'b0;
      num_q   <= '0;
      sel_q   <= '0;
    end else begin
      take_q  <= win_valid;
      halt_q  <= win_valid && win_fault && catch_w;
      fault_q <= win_valid && win_fault;
      num_q   <= win_valid ? win_num : '0;
      sel_q   <= win_sel;
    end
  end

  assign take     = take_q;
  assign take_num = num_q;
  assign halt_req = halt_q;
endmodule

// File: rtl/epm_unit_chk.sv
module epm_unit_chk #(
  parameter int NUM_CFG = 7,
  parameter int NW      = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          take,
  input logic [NW-1:0] take_num,
  input logic          halt_req,
  input logic          svc_req,
  input logic          gmask,
  input logic          catch_en,
  input logic          exec_in_fault,
  input logic          fault_pend
);
  assert_take_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);

  assert_idle_num_R1: assert property (@(posedge clk) disable iff (rst)
    !take |-> take_num == '0);

  assert_num_range_R3: assert property (@(posedge clk) disable iff (rst)
    take |-> (take_num != '0 && int'(take_num) <= NUM_CFG + 1));

  assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (take && take_num != NW'(1)) |-> !$past(gmask));

  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (rst)
    take |-> !$past(exec_in_fault));

  assert_halt_only_fault_R9: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> (take && take_num == NW'(1) && $past(catch_en)));

  assert_escalate_R7: assert property (@(posedge clk) disable iff (rst)
    (svc_req && gmask) |=> fault_pend);
endmodule

bind epm_unit epm_unit_chk #(.NUM_CFG(NUM_CFG), .NW(NW)) u_chk (
  .clk(clk), .rst(rst), .take(take), .take_num(take_num), .halt_req(halt_req),
  .svc_req(svc_req), .gmask(gmask_w), .catch_en(catch_w),
  .exec_in_fault(exec_in_fault), .fault_pend(fault_pend_w)
);

// File: tb/epm_unit_bench.sv
`timescale 1ns/1ps
module epm_unit_bench;
  localparam int NL = 6;
  localparam int AW = 4;
  localparam int NW = 4;
  localparam int A_MASK = 7, A_THR = 8, A_CATCH = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0] line_req = '0;
  logic svc_req = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic exec_active = 1'b0;
  logic [7:0] exec_prio = '0;
  logic exec_in_fault = 1'b0;
  logic take, halt_req;
  logic [NW-1:0] take_num;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  epm_unit #(.NUM_LINES(NL), .PRIO_BITS(3)) u_epm_unit (
    .clk(clk), .rst(rst), .line_req(line_req), .svc_req(svc_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .exec_active(exec_active), .exec_prio(exec_prio),
    .exec_in_fault(exec_in_fault),
    .take(take), .take_num(take_num), .halt_req(halt_req)
  );

  // fields: lines, svc, mask, thr, exec_active, exec_prio, catch, exp take, exp num, exp halt
  function automatic logic [31:0] mk(logic [5:0] ln, logic sv, logic gm, logic [7:0] th,
                                     logic ea, logic [7:0] ep, logic ct,
                                     logic et, logic [3:0] en, logic eh);
    return {ln, sv, gm, th, ea, ep, ct, et, en, eh};
  endfunction

  // base priorities after trimming: svc 60, L0 80, L1 40, L2 40, L3 A0, L4 20, L5 E0
  localparam int NV = 18;
  localparam logic [31:0] VEC [NV] = '{
    mk(6'b000001,0,0,8'h00,0,8'h00,0, 1,4'd3,0), // R3 single line
    mk(6'b000110,0,0,8'h00,0,8'h00,0, 1,4'd4,0), // R3 tie, lower number
    mk(6'b111111,0,0,8'h00,0,8'h00,0, 1,4'd7,0), // R3 smallest value
    mk(6'b000001,1,0,8'h00,0,8'h00,0, 1,4'd2,0), // R3 svc beats L0
    mk(6'b000010,1,0,8'h00,0,8'h00,0, 1,4'd4,0), // R3 L1 beats svc
    mk(6'b111111,0,1,8'h00,0,8'h00,0, 0,4'd0,0), // R4 all masked
    mk(6'b000000,1,1,8'h00,0,8'h00,0, 1,4'd1,0), // R7 escalate, no catch
    mk(6'b000000,1,1,8'h00,0,8'h00,1, 1,4'd1,1), // R9 escalate with catch
    mk(6'b111111,0,0,8'h40,0,8'h00,0, 1,4'd7,0), // R5 only below threshold
    mk(6'b001111,0,0,8'h40,0,8'h00,0, 0,4'd0,0), // R5 equal and above blocked
    mk(6'b000000,1,0,8'h60,0,8'h00,1, 1,4'd1,1), // R7 threshold refuses svc
    mk(6'b000001,0,0,8'h00,1,8'h80,0, 0,4'd0,0), // R6 equal to exec level
    mk(6'b001001,0,0,8'h00,1,8'hA0,0, 1,4'd3,0), // R6 only more urgent
    mk(6'b000000,1,0,8'h00,1,8'h60,0, 1,4'd1,0), // R7 exec level refuses svc
    mk(6'b111111,1,0,8'h00,0,8'h00,0, 1,4'd7,0), // R3 svc admitted but loses
    mk(6'b111111,1,1,8'h00,0,8'h00,1, 1,4'd1,1), // R8 fault beats all lines
    mk(6'b100000,0,0,8'h00,0,8'h00,0, 1,4'd8,0), // R5 zero threshold passes E0
    mk(6'b101000,0,0,8'h00,1,8'hE0,0, 1,4'd6,0)  // R6 L3 under E0
  };
  localparam int VREQ [NV] = '{3,3,3,3,3,4,7,9,5,5,7,6,6,7,3,8,5,6};

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    line_req = '0; svc_req = 1'b0; wr_en = 1'b0;
    exec_active = 1'b0; exec_prio = '0; exec_in_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic prog_base();
    wr(0, 8'h6F); wr(1, 8'h9F); wr(2, 8'h55); wr(3, 8'h40);
    wr(4, 8'hA3); wr(5, 8'h3E); wr(6, 8'hFF);
  endtask

  // pulse requests for one cycle; returns at the negedge after the decision edge
  task automatic fire(input logic [NL-1:0] ln, input logic sv);
    @(negedge clk);
    line_req = ln; svc_req = sv;
    @(negedge clk);
    line_req = '0; svc_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int cnt;

    // R1 reset state
    do_reset();
    @(negedge clk);
    chk("R1", "take", int'(take), 0);
    chk("R1", "halt", int'(halt_req), 0);
    chk("R1", "num", int'(take_num), 0);
    rd(0, d);       chk("R1", "svc prio", int'(d), 0);
    rd(A_MASK, d);  chk("R1", "mask", int'(d), 0);
    rd(A_THR, d);   chk("R1", "threshold", int'(d), 0);
    rd(A_CATCH, d); chk("R1", "catch", int'(d), 0);

    // R2 truncation and map
    wr(1, 8'h9F);       rd(1, d);       chk("R2", "L0 prio trimmed", int'(d), 8'h80);
    wr(A_THR, 8'h5F);   rd(A_THR, d);   chk("R2", "threshold trimmed", int'(d), 8'h40);
    wr(A_MASK, 8'hFE);  rd(A_MASK, d);  chk("R2", "mask bit0 only", int'(d), 0);
    wr(A_MASK, 8'hFF);  rd(A_MASK, d);  chk("R2", "mask set", int'(d), 1);
    wr(A_CATCH, 8'hFF); rd(A_CATCH, d); chk("R2", "catch set", int'(d), 1);
    rd(12, d);                          chk("R2", "unmapped", int'(d), 0);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", VREQ[i]);
      do_reset();
      prog_base();
      wr(A_MASK, {7'd0, v[24]});
      wr(A_THR, v[23:16]);
      wr(A_CATCH, {7'd0, v[6]});
      exec_active = v[15];
      exec_prio = v[14:7];
      fire(v[31:26], v[25]);
      chk(rq, $sformatf("vec %0d take", i), int'(take), int'(v[5]));
      chk(rq, $sformatf("vec %0d num", i), int'(take_num), int'(v[4:1]));
      chk(rq, $sformatf("vec %0d halt", i), int'(halt_req), int'(v[0]));
    end

    // R10 pulse, no retake, back-to-back spacing
    do_reset(); prog_base();
    fire(6'b000001, 1'b0);
    chk("R10", "first take", int'(take), 1);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (take) cnt++;
    end
    chk("R10", "no retake", cnt, 0);
    fire(6'b000011, 1'b0);
    chk("R10", "L1 first", int'(take_num), 4);
    @(negedge clk);
    chk("R10", "gap cycle", int'(take), 0);
    @(negedge clk);
    chk("R10", "L0 second", int'(take_num), 3);

    // R8 fault held while in fault handler, taken once released
    do_reset(); prog_base();
    wr(A_MASK, 8'h01);
    exec_in_fault = 1'b1;
    fire(6'b000000, 1'b1);
    cnt = 0;
    for (int k = 0; k < 3; k++) begin
      if (take) cnt++;
      @(negedge clk);
    end
    chk("R8", "held in fault", cnt, 0);
    exec_in_fault = 1'b0;
    @(negedge clk);
    chk("R8", "fault after release", int'(take_num), 1);

    // R11 svc most urgent, threshold one step below
    do_reset(); prog_base();
    wr(0, 8'h1F);
    wr(A_THR, 8'h20);
    fire(6'b111111, 1'b1);
    chk("R11", "svc taken", int'(take_num), 2);
    chk("R11", "no halt", int'(halt_req), 0);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (take) cnt++;
    end
    chk("R11", "lines blocked", cnt, 0);
    wr(A_THR, 8'h00);
    @(negedge clk);
    chk("R11", "L4 after release", int'(take_num), 7);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule